// File: doc/BRIEF.md
# Programmable Port Mode Controller

This block is the processor-side register file of a 24-line parallel I/O interface. A processor reaches it through a chip select, active-low read and write strobes and a two-bit address. Through that bus it loads a mode word, writes the output latches of three 8-bit ports (A, B, C), flips single bits of port C, and reads back the ports or the control word. From the mode word the block derives a per-line output enable for every port line. It also supplies the group modes and interrupt-enable flags used by the external handshake engines.

Port C is special. In modes 1 and 2 some of its lines belong to handshake signals. The block decides which lines are ordinary I/O, which are handshake outputs and which are strobe or acknowledge inputs. When port C is read, it places the handshake status supplied from outside, or an interrupt-enable flag, in the owned positions. The bus strobes are synchronized to the system clock. A write takes effect once, on the clock edge where the synchronized write strobe is first seen active.

Top module: `ppi_ctrl`

## Requirements
- R1: Address 0 reaches port A, 1 port B, 2 port C and 3 the control word, for both writes and reads. A write commits once per strobe assertion.
- R2: With cs_n high, or with rd_n and wr_n both low, rdata_oe stays low and no register changes.
- R3: After reset, the control word reads 0x9B, every output enable is 0, and every latch and interrupt flag is 0.
- R4: The control word reads back with bit 7 always 1. Its fields are: bits 6:5 group A mode (00 = mode 0, 01 = mode 1, 1x = mode 2), bit 4 port A input, bit 3 port C upper input, bit 2 group B mode 1, bit 1 port B input, bit 0 port C lower input.
- R5: In mode 0, each output enable is the inverse of its direction bit. A read returns the pins for an input port or nibble, and the latch for an output one.
- R6: A control write with bit 7 = 1 loads the mode and clears every port latch and all three interrupt-enable flags.
- R7: A control write with bit 7 = 0 is a bit command. Bits 3:1 give the port C bit number, and bit 0 gives the value (1 = set). It changes only that latch bit, and only when the line is an output, including handshake outputs. It has no effect on an ordinary input line.
- R8: A bit command aimed at a strobe or acknowledge input position changes an interrupt-enable flag instead of the latch. The mapping is: position 2 goes to inte[0] (group B mode 1); position 4 goes to inte[1] (group A mode 1 input, or mode 2); position 6 goes to inte[2] (group A mode 1 output, or mode 2). A port C read shows the flag in that position.
- R9: A plain port C write changes only nibbles whose group is in mode 0 and whose direction is output.
- R10: In modes 1 and 2, port C is laid out as follows. Handshake outputs are lines 0 and 1 (group B), line 3, and line 5 (A input or mode 2) or line 7 (A output or mode 2). These lines have their output enable set and read back hs_stat. Strobe and acknowledge lines have their output enable cleared. In mode 2, pa_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from processor |
| rdata | output | 8 | Read data to processor |
| rdata_oe | output | 1 | Drive enable for the read data |
| pa_in | input | 8 | Port A pin values |
| pb_in | input | 8 | Port B pin values |
| pc_in | input | 8 | Port C pin values |
| hs_stat | input | 8 | Handshake status for owned port C positions |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-line output enable |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-line output enable |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-line output enable |
| grp_a_mode | output | 2 | Group A mode field |
| grp_b_mode | output | 1 | Group B mode 1 select |
| inte | output | 3 | Interrupt-enable flags {A output, A input, B} |

## Verification
The main function is exercised with several mode words: all ports output in mode 0, mixed input and output in mode 0, both groups in strobed-input mode 1, and group A in mode 2. These patterns separate the direction decode from the port C ownership decode. Bit commands are sent to an ordinary output, an ordinary input, a handshake output and each strobe or acknowledge position, so that latch writes, ignored commands and flag updates can be told apart. Plain port C writes with all ones, made under each configuration, show whether the nibble mask follows the group mode. A mode write after flags and latches have been set shows whether everything is cleared.

// File: rtl/ppi_pkg.sv
`timescale 1ns/1ps
package ppi_pkg;
  localparam int PW = 8;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } ppi_cfg_t;

  localparam ppi_cfg_t CFG_RESET = 7'b0011011;

  // strobe / acknowledge positions owned by handshake inputs
  function automatic logic [PW-1:0] pc_hs_in(ppi_cfg_t c);
    logic [PW-1:0] m;
    m = '0;
    if (c.b_mode) m[2] = 1'b1;
    if (c.a_mode[1]) begin
      m[4] = 1'b1;
      m[6] = 1'b1;
    end else if (c.a_mode[0]) begin
      if (c.a_in) m[4] = 1'b1;
      else        m[6] = 1'b1;
    end
    return m;
  endfunction

  // positions owned by handshake outputs
  function automatic logic [PW-1:0] pc_hs_out(ppi_cfg_t c);
    logic [PW-1:0] m;
    m = '0;
    if (c.b_mode) begin
      m[0] = 1'b1;
      m[1] = 1'b1;
    end
    if (c.a_mode[1]) begin
      m[3] = 1'b1;
      m[5] = 1'b1;
      m[7] = 1'b1;
    end else if (c.a_mode[0]) begin
      m[3] = 1'b1;
      if (c.a_in) m[5] = 1'b1;
      else        m[7] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [PW-1:0] pc_general_out(ppi_cfg_t c);
    logic [PW-1:0] gen;
    gen = ~(pc_hs_in(c) | pc_hs_out(c));
    return gen & {{(PW/2){~c.cu_in}}, {(PW/2){~c.cl_in}}};
  endfunction

  function automatic logic [PW-1:0] pc_oe_mask(ppi_cfg_t c);
    return pc_hs_out(c) | pc_general_out(c);
  endfunction

  // bits a plain port C write may touch
  function automatic logic [PW-1:0] pc_plain_mask(ppi_cfg_t c);
    logic [PW/2-1:0] up, lo;
    up = (c.a_mode == 2'b00 && !c.cu_in) ? '1 : '0;
    lo = (!c.b_mode && !c.cl_in) ? '1 : '0;
    return {up, lo};
  endfunction

  function automatic logic [PW-1:0] inte_spread(logic [2:0] f);
    return {1'b0, f[2], 1'b0, f[1], 1'b0, f[0], 2'b00};
  endfunction
endpackage

// File: rtl/ppi_bus_sync.sv
`timescale 1ns/1ps
module ppi_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_pulse
);
  localparam int CHAIN = STAGES + 1;

  logic             wr_act;
  logic [CHAIN-1:0] chain;

  assign wr_act   = ~cs_n & ~wr_n & rd_n;
  assign wr_pulse = chain[STAGES-1] & ~chain[STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CHAIN-2:0], wr_act};
  end

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse); // R1
endmodule

// File: rtl/ppi_ctrl_regs.sv
`timescale 1ns/1ps
module ppi_ctrl_regs
  import ppi_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_pulse,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] wdata,
  output ppi_cfg_t      cfg,
  output logic [PW-1:0] pa_lat,
  output logic [PW-1:0] pb_lat,
  output logic [PW-1:0] pc_lat,
  output logic [2:0]    inte_q
);
  logic          mode_wr, sr_wr, plain_c_wr;
  logic [2:0]    sr_idx;
  logic          sr_val;
  logic [PW-1:0] hs_in_m, oe_m, plain_m;
  logic          sr_to_flag, sr_to_latch, sr_ignored;

  assign mode_wr    = wr_pulse && addr == 2'd3 && wdata[7];
  assign sr_wr      = wr_pulse && addr == 2'd3 && !wdata[7];
  assign plain_c_wr = wr_pulse && addr == 2'd2;
  assign sr_idx     = wdata[3:1];
  assign sr_val     = wdata[0];
  assign hs_in_m    = pc_hs_in(cfg);
  assign oe_m       = pc_oe_mask(cfg);
  assign plain_m    = pc_plain_mask(cfg);
  assign sr_to_flag  = sr_wr && hs_in_m[sr_idx];
  assign sr_to_latch = sr_wr && oe_m[sr_idx];
  assign sr_ignored  = sr_wr && !hs_in_m[sr_idx] && !oe_m[sr_idx];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cfg    <= CFG_RESET;
      pa_lat <= '0;
      pb_lat <= '0;
      pc_lat <= '0;
      inte_q <= '0;
    end else if (mode_wr) begin
      cfg    <= ppi_cfg_t'(wdata[6:0]);
      pa_lat <= '0;
      pb_lat <= '0;
      pc_lat <= '0;
      inte_q <= '0;
    end else begin
      if (wr_pulse && addr == 2'd0) pa_lat <= wdata;
      if (wr_pulse && addr == 2'd1) pb_lat <= wdata;
      if (plain_c_wr) pc_lat <= (pc_lat & ~plain_m) | (wdata & plain_m);
      if (sr_to_latch) pc_lat[sr_idx] <= sr_val;
      if (sr_to_flag) begin
        case (sr_idx)
          3'd2:    inte_q[0] <= sr_val;
          3'd4:    inte_q[1] <= sr_val;
          3'd6:    inte_q[2] <= sr_val;
          default: ;
        endcase
      end
    end
  end

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (pa_lat == '0 && pb_lat == '0 && pc_lat == '0 && inte_q == '0)); // R6
  AST_SR_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
    sr_wr |=> ($countones(pc_lat ^ $past(pc_lat)) <= 1)); // R7
  AST_SR_INPUT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    sr_ignored |=> ($stable(pc_lat) && $stable(inte_q))); // R7
  AST_SR_FLAG_NOT_LATCH: assert property (@(posedge clk) disable iff (rst)
    sr_to_flag |=> $stable(pc_lat)); // R8
  AST_PLAIN_C_MASK: assert property (@(posedge clk) disable iff (rst)
    plain_c_wr |=> (((pc_lat ^ $past(pc_lat)) & ~$past(plain_m)) == '0)); // R9
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mode_wr |=> $stable(cfg)); // R6
endmodule

// File: rtl/ppi_read_mux.sv
`timescale 1ns/1ps
module ppi_read_mux
  import ppi_pkg::*;
(
  input  logic [1:0]    addr,
  input  ppi_cfg_t      cfg,
  input  logic [PW-1:0] pa_lat,
  input  logic [PW-1:0] pb_lat,
  input  logic [PW-1:0] pc_lat,
  input  logic [2:0]    inte_q,
  input  logic [PW-1:0] pa_in,
  input  logic [PW-1:0] pb_in,
  input  logic [PW-1:0] pc_in,
  input  logic [PW-1:0] hs_stat,
  output logic [PW-1:0] rd_val
);
  logic [PW-1:0] hs_in_m, hs_out_m, gen_out_m, gen_in_m, pc_view;
  logic          a_pins;

  assign hs_in_m   = pc_hs_in(cfg);
  assign hs_out_m  = pc_hs_out(cfg);
  assign gen_out_m = pc_general_out(cfg);
  assign gen_in_m  = ~(hs_in_m | hs_out_m | gen_out_m);
  assign a_pins    = cfg.a_in | cfg.a_mode[1];

  assign pc_view = (inte_spread(inte_q) & hs_in_m)
                 | (hs_stat & hs_out_m)
                 | (pc_lat & gen_out_m)
                 | (pc_in & gen_in_m);

  always_comb begin
    case (addr)
      2'd0:    rd_val = a_pins ? pa_in : pa_lat;
      2'd1:    rd_val = cfg.b_in ? pb_in : pb_lat;
      2'd2:    rd_val = pc_view;
      default: rd_val = {1'b1, cfg};
    endcase
  end
endmodule

// File: rtl/ppi_ctrl.sv
`timescale 1ns/1ps
module ppi_ctrl
  import ppi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rdata_oe,
  input  logic [7:0] pa_in,
  input  logic [7:0] pb_in,
  input  logic [7:0] pc_in,
  input  logic [7:0] hs_stat,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe,
  output logic [1:0] grp_a_mode,
  output logic       grp_b_mode,
  output logic [2:0] inte
);
  logic          wr_pulse;
  ppi_cfg_t      cfg;
  logic [PW-1:0] pa_lat, pb_lat, pc_lat, rd_val;
  logic [2:0]    inte_q;

  ppi_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .wr_pulse(wr_pulse)
  );

  ppi_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .addr(addr), .wdata(wdata),
    .cfg(cfg), .pa_lat(pa_lat), .pb_lat(pb_lat), .pc_lat(pc_lat),
    .inte_q(inte_q)
  );

  ppi_read_mux u_rmux (
    .addr(addr), .cfg(cfg), .pa_lat(pa_lat), .pb_lat(pb_lat),
    .pc_lat(pc_lat), .inte_q(inte_q), .pa_in(pa_in), .pb_in(pb_in),
    .pc_in(pc_in), .hs_stat(hs_stat), .rd_val(rd_val)
  );

  assign rdata_oe   = ~cs_n & ~rd_n & wr_n;
  assign rdata      = rdata_oe ? rd_val : '0;
  assign pa_out     = pa_lat;
  assign pb_out     = pb_lat;
  assign pc_out     = pc_lat;
  assign pa_oe      = (cfg.a_in | cfg.a_mode[1]) ? '0 : '1;
  assign pb_oe      = cfg.b_in ? '0 : '1;
  assign pc_oe      = pc_oe_mask(cfg);
  assign grp_a_mode = cfg.a_mode;
  assign grp_b_mode = cfg.b_mode;
  assign inte       = inte_q;

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cs_n || (!rd_n && !wr_n)) |-> !rdata_oe); // R2
  AST_CTRL_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
    (rdata_oe && addr == 2'd3) |-> rdata[7]); // R4
  AST_MODE2_A_FLOAT: assert property (@(posedge clk) disable iff (rst)
    grp_a_mode[1] |-> (pa_oe == '0)); // R10
  AST_STROBE_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    grp_b_mode |-> !pc_oe[2]); // R10
endmodule

// File: tb/tb_ppi_ctrl.sv
`timescale 1ns/1ps
module tb_ppi_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00, hs_stat = 8'h00;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic       rdata_oe, grp_b_mode;
  logic [1:0] grp_a_mode;
  logic [2:0] inte;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ppi_ctrl dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in), .hs_stat(hs_stat),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_out(pc_out), .pc_oe(pc_oe), .grp_a_mode(grp_a_mode),
    .grp_b_mode(grp_b_mode), .inte(inte)
  );

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1;
    d = rdata; oe = rdata_oe;
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic oe;
    bus_rd(2'd3, d, oe);
    chk("R3 control after reset", d, 8'h9B);
    chk("R4 read drives bus", {7'd0, oe}, 8'h01);
    chk("R3 pa_oe", pa_oe, 8'h00);
    chk("R3 pb_oe", pb_oe, 8'h00);
    chk("R3 pc_oe", pc_oe, 8'h00);
    chk("R3 latches", pa_out | pb_out | pc_out, 8'h00);
  endtask

  task automatic t_mode0();
    logic [7:0] d; logic oe;
    bus_wr(2'd3, 8'h80);
    chk("R5 pa_oe all out", pa_oe, 8'hFF);
    chk("R5 pc_oe all out", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'h96);
    chk("R1 port A latch", pa_out, 8'h5A);
    chk("R1 port B latch", pb_out, 8'hC3);
    chk("R1 port C latch", pc_out, 8'h96);
    bus_rd(2'd0, d, oe);
    chk("R5 read A output latch", d, 8'h5A);
    bus_rd(2'd3, d, oe);
    chk("R4 control readback", d, 8'h80);
    bus_wr(2'd3, 8'h91);
    chk("R6 B latch cleared", pb_out, 8'h00);
    chk("R6 C latch cleared", pc_out, 8'h00);
    chk("R5 pa_oe input", pa_oe, 8'h00);
    chk("R5 pc_oe lower input", pc_oe, 8'hF0);
    pa_in = 8'h3C;
    bus_rd(2'd0, d, oe);
    chk("R5 read A pins", d, 8'h3C);
    bus_wr(2'd2, 8'hFF);
    chk("R9 plain C only upper", pc_out, 8'hF0);
    pc_in = 8'h05;
    bus_rd(2'd2, d, oe);
    chk("R5 read C mixed", d, 8'hF5);
    bus_rd(2'd3, d, oe);
    chk("R4 control 0x91", d, 8'h91);
  endtask

  task automatic t_bus_gate();
    logic [7:0] d; logic oe;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h11);
    @(negedge clk);
    addr = 2'd0; wdata = 8'hEE; cs_n = 1'b1; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 write ignored without select", pa_out, 8'h11);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; wdata = 8'h77;
    #1;
    chk("R2 no drive with both strobes", {7'd0, rdata_oe}, 8'h00);
    repeat (4) @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 no write with both strobes", pa_out, 8'h11);
    @(negedge clk);
    rd_n = 1'b0; cs_n = 1'b1;
    #1;
    chk("R2 no drive without select", {7'd0, rdata_oe}, 8'h00);
    @(negedge clk);
    rd_n = 1'b1;
  endtask

  task automatic t_bitcmd();
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'h0B);
    chk("R7 set bit 5", pc_out, 8'h20);
    bus_wr(2'd3, 8'h01);
    chk("R7 set bit 0", pc_out, 8'h21);
    bus_wr(2'd3, 8'h0A);
    chk("R7 clear bit 5", pc_out, 8'h01);
    bus_wr(2'd3, 8'h81);
    bus_wr(2'd3, 8'h03);
    chk("R7 input line ignored", pc_out, 8'h00);
  endtask

  task automatic t_handshake();
    logic [7:0] d; logic oe;
    bus_wr(2'd3, 8'hB6);
    chk("R10 pc_oe mode1 inputs", pc_oe, 8'hEB);
    chk("R10 pa_oe mode1 input", pa_oe, 8'h00);
    chk("R4 group modes", {5'd0, grp_a_mode, grp_b_mode}, 8'h03);
    bus_wr(2'd3, 8'h09);
    bus_wr(2'd3, 8'h05);
    chk("R8 flags A-in and B", {5'd0, inte}, 8'h03);
    chk("R8 latch untouched", pc_out, 8'h00);
    hs_stat = 8'hFF; pc_in = 8'h00;
    bus_rd(2'd2, d, oe);
    chk("R10 port C status view", d, 8'h3F);
    bus_wr(2'd3, 8'h07);
    chk("R7 handshake output line", pc_out, 8'h08);
    bus_wr(2'd2, 8'hFF);
    chk("R9 plain C with no mode-0 group", pc_out, 8'h08);
    bus_wr(2'd3, 8'h0D);
    chk("R7 general line in mode 1", pc_out, 8'h48);
    chk("R8 flags unchanged", {5'd0, inte}, 8'h03);
    bus_wr(2'd3, 8'hC0);
    chk("R6 flags cleared", {5'd0, inte}, 8'h00);
    chk("R6 latch cleared", pc_out, 8'h00);
    chk("R10 mode2 pa_oe", pa_oe, 8'h00);
    chk("R10 mode2 pc_oe", pc_oe, 8'hAF);
    bus_wr(2'd3, 8'h0D);
    chk("R8 flag A-out in mode 2", {5'd0, inte}, 8'h04);
    bus_wr(2'd3, 8'h08);
    chk("R8 clear flag A-in stays clear", {5'd0, inte}, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_mode0();
    t_bus_gate();
    t_bitcmd();
    t_handshake();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule